// File: doc/BRIEF.md
# Grayscale Frame Loader for Chained LED Drivers

This block pushes one complete grayscale frame into a daisy chain of constant-current LED driver chips over a serial link. The link has three wires: a shift clock, a serial data line and a latch line. The block reads 16-bit grayscale words from a synchronous frame-buffer read port. It shifts each word out most significant bit first. The driver chips decode a command from the number of shift-clock periods during which the latch line is held high.

A frame is organised as a number of multiplexed scan lines. For every line, each driver in the chain needs one word per colour channel. After the words of one line group have been shifted, the block marks the group with a one-period data-latch command. After the last group, it issues a three-period frame-sync command. The drivers keep the whole frame in their own memory, so the block transmits only when a start strobe requests a frame. A request that arrives while a frame is in flight is remembered and served straight afterwards.

Top module: `gs_frame_loader`

## Requirements
- R1: While reset is held and after it is released with no request, busy_o, done_o, sclk_o, sin_o and lat_o are all 0.
- R2: Each word is sent most significant bit first, one bit per sclk_o period. sin_o changes only while sclk_o is low, and is stable during the whole high phase, so the receiver samples it on the sclk_o rising edge.
- R3: Within a frame, lines go in ascending order. Inside a line, channels go in ascending order from 0 to GRP_WORDS-1. For each channel, NUM_DRV words are sent with the farthest driver first, i.e. driver index NUM_DRV-1 down to 0. The word for line L, driver D and channel C is read from address (L*NUM_DRV + D)*GRP_WORDS + C, with one cycle of read latency.
- R4: lat_o is high for exactly one sclk_o period, coinciding with the least significant bit of the last word of each line group (GRP_WORDS*NUM_DRV words). It is low during every other data bit.
- R5: After the last line group, the block sends one separator period with lat_o and sin_o low. It then sends three sclk_o periods with lat_o high and sin_o low, so a frame spans TOTAL*WORD_W+4 sclk_o periods. No latch pulse has any width other than 1 or 3 periods.
- R6: busy_o is high from the cycle after an accepted start until the frame ends. done_o is a single-cycle pulse at the end of each frame, and busy_o is low in that cycle.
- R7: Without a start request, sclk_o and lat_o stay low; frames are never refreshed on their own.
- R8: A start_i seen while busy_o is high is held, and exactly one further frame follows the current one, however many such requests arrive.
- R9: rd_addr_o always stays within 0 to TOTAL-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to transmit one frame |
| busy_o | output | 1 | A frame is being transmitted |
| done_o | output | 1 | One-cycle pulse at frame end |
| rd_addr_o | output | AW | Frame-buffer read address |
| rd_data_i | input | WORD_W | Frame-buffer read data, valid one cycle after the address |
| sclk_o | output | 1 | Serial shift clock |
| sin_o | output | 1 | Serial data, MSB first |
| lat_o | output | 1 | Latch line; its width in sclk_o periods encodes the command |

## Verification
The hardest situation to reach from the ports is a second request that lands near a frame boundary. Examples are a request during the frame-sync tail, or in the same cycle the sequencer returns to idle, where a dropped or doubled frame would show up. The bench fires extra start pulses at random offsets that sweep the whole frame length, including the closing sync periods. It also sends bursts of several pulses inside one frame. For each case it checks that exactly two frames appear on the serial link and that both carry the right bits and latch pattern.

// File: rtl/gfl_pkg.sv
// Shared definitions for the grayscale frame loader.
package gfl_pkg;

    // Sequencer states: idle, two-cycle word fetch, bit shifting, sync tail.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH_A = 3'd1,
        ST_FETCH_D = 3'd2,
        ST_SHIFT   = 3'd3,
        ST_SYNC    = 3'd4
    } gfl_state_t;

    // Sync tail: one separator period, then three latch-high periods.
    localparam logic [1:0] SYNC_LAST = 2'd3;

endpackage

// File: rtl/gfl_addr_gen.sv
// gfl_addr_gen: walks line, channel and driver counters in transmit order
// and forms the frame-buffer read address.
// Assumes: clr and step are never high together; the driver index counts
// down so that the farthest driver's word is sent first.
module gfl_addr_gen #(
    parameter int NUM_DRV   = 2,
    parameter int GRP_WORDS = 48,
    parameter int NUM_LINES = 32,
    parameter int AW        = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] rd_addr,
    output logic          grp_last,
    output logic          frame_last
);
    localparam int TOTAL = NUM_DRV * GRP_WORDS * NUM_LINES;
    localparam int DW    = (NUM_DRV   > 1) ? $clog2(NUM_DRV)   : 1;
    localparam int CW    = (GRP_WORDS > 1) ? $clog2(GRP_WORDS) : 1;
    localparam int LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [DW-1:0] drv;
    logic [CW-1:0] ch;
    logic [LW-1:0] line;

    // Advance driver (down), then channel, then line at the end of each word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            drv  <= DW'(NUM_DRV - 1);
            ch   <= '0;
            line <= '0;
        end else if (step) begin
            if (drv != '0) begin
                drv <= drv - 1'b1;
            end else begin
                drv <= DW'(NUM_DRV - 1);
                if (ch == CW'(GRP_WORDS - 1)) begin
                    ch   <= '0;
                    line <= (line == LW'(NUM_LINES - 1)) ? '0 : line + 1'b1;
                end else begin
                    ch <= ch + 1'b1;
                end
            end
        end
    end

    // Buffer layout: per line, per driver, a run of channel words.
    always_comb begin
        rd_addr = AW'((int'(line) * NUM_DRV + int'(drv)) * GRP_WORDS + int'(ch));
    end

    // Flags for the last word of a line group and of the frame.
    assign grp_last   = (drv == '0) && (ch == CW'(GRP_WORDS - 1));
    assign frame_last = grp_last && (line == LW'(NUM_LINES - 1));

    // R9: the computed address never leaves the frame buffer.
    a_r9_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr) < TOTAL);

endmodule

// File: rtl/gfl_shifter.sv
// gfl_shifter: holds one grayscale word and presents its bits MSB first,
// counting how many have gone out.
// Assumes: load and shift are never high together.
module gfl_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              msb,
    output logic              bit_last
);
    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] sh;
    logic [BW-1:0]     cnt;

    // Load a fresh word or move to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= din;
            cnt <= '0;
        end else if (shift) begin
            sh  <= {sh[WORD_W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    assign msb      = sh[WORD_W-1];
    assign bit_last = (cnt == BW'(WORD_W - 1));

    // R2: the sequencer never shifts past the last bit of a word.
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !bit_last);

endmodule

// File: rtl/gs_frame_loader.sv
// gs_frame_loader: on request, streams one grayscale frame into a chain of
// LED drivers over sclk/sin, marking each line group with a one-period
// latch and the frame end with a three-period latch.
// Assumes: a synchronous read port with one cycle of latency; a start seen
// while busy is held and served after the current frame.
module gs_frame_loader #(
    parameter int NUM_DRV   = 2,
    parameter int GRP_WORDS = 48,
    parameter int NUM_LINES = 32,
    parameter int WORD_W    = 16,
    localparam int TOTAL    = NUM_DRV * GRP_WORDS * NUM_LINES,
    localparam int AW       = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              sclk_o,
    output logic              sin_o,
    output logic              lat_o
);
    import gfl_pkg::*;

    gfl_state_t st;
    logic       ph;
    logic [1:0] vcnt;
    logic       pend;
    logic       done_q;
    logic       grp_last, frame_last, msb, bit_last;
    logic       go, a_clr, a_step, s_load, s_shift;

    // Control strobes derived from the sequencer state.
    always_comb begin
        go      = start_i || pend;
        a_clr   = (st == ST_IDLE) && go;
        a_step  = (st == ST_SHIFT) && ph && bit_last && !frame_last;
        s_load  = (st == ST_FETCH_D);
        s_shift = (st == ST_SHIFT) && ph && !bit_last;
    end

    gfl_addr_gen #(
        .NUM_DRV   (NUM_DRV),
        .GRP_WORDS (GRP_WORDS),
        .NUM_LINES (NUM_LINES),
        .AW        (AW)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (a_clr),
        .step       (a_step),
        .rd_addr    (rd_addr_o),
        .grp_last   (grp_last),
        .frame_last (frame_last)
    );

    gfl_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (s_load),
        .shift    (s_shift),
        .din      (rd_data_i),
        .msb      (msb),
        .bit_last (bit_last)
    );

    // Sequencer: fetch, shift each bit over a low and a high phase, then sync tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            ph     <= 1'b0;
            vcnt   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE:    if (go) st <= ST_FETCH_A;
                ST_FETCH_A: st <= ST_FETCH_D;
                ST_FETCH_D: begin
                    st <= ST_SHIFT;
                    ph <= 1'b0;
                end
                ST_SHIFT: begin
                    ph <= !ph;
                    if (ph && bit_last) begin
                        st   <= frame_last ? ST_SYNC : ST_FETCH_A;
                        vcnt <= '0;
                    end
                end
                ST_SYNC: begin
                    ph <= !ph;
                    if (ph) begin
                        if (vcnt == SYNC_LAST) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            vcnt <= vcnt + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Remember one request that arrives while a frame is running.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_IDLE) pend <= 1'b0;
        else if (start_i)           pend <= 1'b1;
    end

    // Serial outputs decoded from sequencer flops.
    assign sclk_o = ((st == ST_SHIFT) || (st == ST_SYNC)) && ph;
    assign sin_o  = (st == ST_SHIFT) && msb;
    assign lat_o  = ((st == ST_SHIFT) && grp_last && bit_last)
                 || ((st == ST_SYNC) && (vcnt != 2'd0));
    assign busy_o = (st != ST_IDLE);
    assign done_o = done_q;

    // Checker counter: sclk high phases seen during the current latch pulse.
    logic [2:0] lat_pw;
    always_ff @(posedge clk) begin
        if (!rst_n || !lat_o) lat_pw <= '0;
        else if (sclk_o)      lat_pw <= lat_pw + 1'b1;
    end

    // R2: data is held steady across every sclk high phase.
    a_r2_sin_stable: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sin_o));

    // R4 and R5: a latch pulse ends after exactly 1 or 3 sclk periods.
    a_r5_lat_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lat_o) |-> (lat_pw == 3'd1 || lat_pw == 3'd3));

    // R6: the done pulse is reported with busy already low.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: a request while busy is kept for the next frame.
    a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> (pend || busy_o));

    // R7: the serial clock only toggles during a frame.
    a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !lat_o));

endmodule

// File: tb/sim_gs_frame_loader.sv
module sim_gs_frame_loader;
    localparam int CLK_P     = 10;
    localparam int NDRV      = 2;
    localparam int GRP       = 3;
    localparam int LINES     = 2;
    localparam int W         = 16;
    localparam int TOTAL     = NDRV * GRP * LINES;
    localparam int AW        = $clog2(TOTAL);
    localparam int FRAME_P   = TOTAL * W + 4;
    localparam int FRAME_CYC = TOTAL * (2 + 2 * W) + 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          busy_o, done_o, sclk_o, sin_o, lat_o;
    logic [AW-1:0] rd_addr_o;
    logic [W-1:0]  rd_data_i;
    logic [W-1:0]  mem [TOTAL];

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    gs_frame_loader #(
        .NUM_DRV(NDRV), .GRP_WORDS(GRP), .NUM_LINES(LINES), .WORD_W(W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .done_o(done_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .sclk_o(sclk_o), .sin_o(sin_o), .lat_o(lat_o)
    );

    always #(CLK_P / 2) clk = !clk;

    // Frame buffer model with one cycle of read latency.
    always @(posedge clk)
        rd_data_i <= (int'(rd_addr_o) < TOTAL) ? mem[rd_addr_o] : '0;

    // Link monitor: records sin/lat at each sclk rise, counts events.
    bit cap_sin [4096];
    bit cap_lat [4096];
    int cap_n = 0, stab_err = 0, done_cnt = 0, addr_err = 0, idle_act = 0;
    logic sclk_p = 1'b0, sin_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o && !sclk_p) begin
                if (cap_n < 4096) begin
                    cap_sin[cap_n] = sin_o;
                    cap_lat[cap_n] = lat_o;
                end
                cap_n = cap_n + 1;
                if (sin_o !== sin_p) stab_err = stab_err + 1;
            end
            if (done_o) done_cnt = done_cnt + 1;
            if (int'(rd_addr_o) >= TOTAL) addr_err = addr_err + 1;
            if (!busy_o && (sclk_o || lat_o)) idle_act = idle_act + 1;
        end
        sclk_p = sclk_o;
        sin_p  = sin_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected serial data bit for period p of a frame (R2, R3, R5).
    function automatic bit exp_sin(input int p);
        int k, bitn, rem, line, ch, drv;
        if (p >= TOTAL * W) return 1'b0;
        k    = p / W;
        bitn = W - 1 - (p % W);
        line = k / (GRP * NDRV);
        rem  = k % (GRP * NDRV);
        ch   = rem / NDRV;
        drv  = NDRV - 1 - (rem % NDRV);
        return mem[(line * NDRV + drv) * GRP + ch][bitn];
    endfunction

    // Expected latch level for period p of a frame (R4, R5).
    function automatic bit exp_lat(input int p);
        if (p >= TOTAL * W) return (p != TOTAL * W);
        return ((p / W) % (GRP * NDRV) == GRP * NDRV - 1) && (p % W == W - 1);
    endfunction

    task automatic verify_frame(input int base, input string tag);
        int bad_d = 0, bad_l = 0, bad_s = 0, first = -1;
        for (int p = 0; p < FRAME_P; p++) begin
            if (p < TOTAL * W) begin
                if (cap_sin[base + p] != exp_sin(p)) begin
                    bad_d++;
                    if (first < 0) first = p;
                end
                if (cap_lat[base + p] != exp_lat(p)) bad_l++;
            end else begin
                if (cap_sin[base + p] != 1'b0 || cap_lat[base + p] != exp_lat(p)) bad_s++;
            end
        end
        check(bad_d == 0, {"R3 data order ", tag}, bad_d, 0);
        if (bad_d != 0) $display("  first mismatching period %0d", first);
        check(bad_l == 0, {"R4 group latch ", tag}, bad_l, 0);
        check(bad_s == 0, {"R5 sync tail ", tag}, bad_s, 0);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_dones(input int target, output bit ok);
        int n = 0;
        while (done_cnt < target && n < 4 * FRAME_CYC) begin
            @(negedge clk);
            n++;
        end
        ok = (done_cnt >= target);
    endtask

    task automatic run_frame(input string tag);
        int base, d0;
        bit ok;
        bit saw_busy;
        base = cap_n;
        d0   = done_cnt;
        pulse_start();
        saw_busy = busy_o;
        check(saw_busy, {"R6 busy after start ", tag}, busy_o, 1);
        wait_dones(d0 + 1, ok);
        check(ok, {"R6 done pulse ", tag}, done_cnt - d0, 1);
        check(!busy_o, {"R6 idle at done ", tag}, busy_o, 0);
        repeat (3) @(negedge clk);
        check(cap_n - base == FRAME_P, {"R2 period count ", tag}, cap_n - base, FRAME_P);
        verify_frame(base, tag);
    endtask

    task automatic fill_random();
        for (int i = 0; i < TOTAL; i++) mem[i] = W'($urandom);
    endtask

    // Watchdog: a hung run is counted as a failure and still summarised.
    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base, d0, off;
        bit ok;
        void'($urandom(32'd7321));
        for (int i = 0; i < TOTAL; i++) mem[i] = '0;

        // R1: outputs low during and after reset.
        repeat (4) @(negedge clk);
        check({busy_o, done_o, sclk_o, sin_o, lat_o} == 5'b0, "R1 in reset",
              {busy_o, done_o, sclk_o, sin_o, lat_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({busy_o, done_o, sclk_o, sin_o, lat_o} == 5'b0, "R1 after reset",
              {busy_o, done_o, sclk_o, sin_o, lat_o}, 0);

        // Directed patterns.
        for (int i = 0; i < TOTAL; i++) mem[i] = W'(i * 16'h1111 + 1);
        run_frame("index");
        for (int i = 0; i < TOTAL; i++) mem[i] = '1;
        run_frame("ones");
        for (int i = 0; i < TOTAL; i++) mem[i] = W'(1) << (i % W);
        run_frame("walk");
        for (int i = 0; i < TOTAL; i++) mem[i] = (i % 2 == 1) ? 16'hA5A5 : 16'h5A5A;
        run_frame("alt");

        // Random frames.
        for (int r = 0; r < 3; r++) begin
            fill_random();
            run_frame("rand");
        end

        // R7: buffer changes without a request produce no traffic.
        base = cap_n;
        fill_random();
        repeat (FRAME_CYC) @(negedge clk);
        check(cap_n == base, "R7 no refresh", cap_n - base, 0);
        check(idle_act == 0, "R7 idle quiet", idle_act, 0);

        // R8: extra requests at random offsets, including bursts.
        for (int r = 0; r < 6; r++) begin
            fill_random();
            base = cap_n;
            d0   = done_cnt;
            pulse_start();
            off = $urandom_range(0, FRAME_CYC - 4);
            repeat (off) @(negedge clk);
            pulse_start();
            if (r % 2 == 1) begin
                pulse_start();
                pulse_start();
            end
            wait_dones(d0 + 2, ok);
            check(ok, "R8 second frame done", done_cnt - d0, 2);
            repeat (FRAME_CYC) @(negedge clk);
            check(done_cnt - d0 == 2, "R8 exactly two frames", done_cnt - d0, 2);
            check(cap_n - base == 2 * FRAME_P, "R8 period count", cap_n - base, 2 * FRAME_P);
            verify_frame(base, "pend first");
            verify_frame(base + FRAME_P, "pend second");
        end

        check(stab_err == 0, "R2 sin stable at sclk rise", stab_err, 0);
        check(addr_err == 0, "R9 address range", addr_err, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule